// File: doc/BRIEF.md
# Priority Round-Robin Bus Arbiter

The arbiter decides, once per clock, which of eight masters may drive a shared pipelined bus in the next transfer slot. Each master presents a 3-bit priority code. The largest code present wins. When several masters share that code, a rotating order picks among them. Each priority level has its own rotation pointer, so traffic at one level does not disturb the order at another.

A master that already owns the bus can assert its hold line to keep ownership across the cycles of a locked sequence. A stop input freezes arbitration: no master gains the bus while it is high. A holder that keeps hold asserted still keeps the bus.

For systems with more than eight masters, up to eight identical slices are combined. Each slice publishes its best local priority. External logic returns the global best priority and a per-slice token. A slice grants only when its best equals the global best and it holds the token. A lone slice feeds its own best priority back and ties the token high.

Top module: `prra_arbiter`

## Requirements
- R1: After a synchronous reset, the grant output is all zero, and every level's rotation starts from master 0.
- R2: The grant output is one-hot or all zero in every cycle.
- R3: Priority code 7 is the highest and code 1 the lowest. A master with a higher code always wins over one with a lower code.
- R4: Among masters at the winning code, the grant goes to the first requester found in ascending index order (wrapping from 7 to 0), starting just after the master last granted at that same code. Each code keeps its own pointer, which moves only when a grant at that code is issued.
- R5: Priority code 0 means no request. With all codes at 0 the grant is all zero.
- R6: While the current owner asserts its hold bit, it keeps the grant, whatever other requests are present. A hold bit of a master that is not the owner has no effect.
- R7: While stop is high, no new grant is issued and no rotation pointer moves. A grant not held by its owner drops to zero, and a held grant stays.
- R8: A slice issues a new grant only when the global best code input equals its own best code and the cascade token input is high. Otherwise the grant is zero unless a hold keeps it.
- R9: Requests sampled at a clock edge are reflected in the grant output after exactly GNT_STAGES clock edges (default 1), and the grant never changes between edges.
- R10: The cascade best-code output shows the largest priority code among the local requests in the same cycle, or 0 when there are none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pri_i | input | 24 | Priority code per master, 3 bits each; master i uses bits [3i+2:3i] |
| hold_i | input | 8 | Per-master hold request; bit i is master i |
| stop_i | input | 1 | Blocks all new grants |
| cas_best_o | output | 3 | Best local priority code, for the cascade |
| cas_best_i | input | 3 | Global best priority code from the cascade |
| cas_tok_i | input | 1 | Cascade token; this slice may grant at the global best code |
| grant_o | output | 8 | Registered one-hot grant; bit i is master i |

## Verification
The assertions assume that the cascade inputs come from a correct combiner, so that the global best code is never below a code present in this slice. The assertions also assume that hold is only meaningful for the present owner. The stimulus keeps to these assumptions. It runs a single slice by looping the best-code output back with the token high. It switches to explicitly driven cascade values only in the cascade scenario, and there it gives a global best code at or above the local one. Inputs change only away from the clock edge, and the bench returns every input to idle between scenarios.

// File: rtl/prra_pkg.sv
package prra_pkg;
  localparam int unsigned PRI_W = 3;
  localparam int unsigned NUM_LVL = 2 ** PRI_W;

  typedef enum logic [1:0] {
    NXT_KEEP = 2'd0,
    NXT_IDLE = 2'd1,
    NXT_NEW  = 2'd2
  } nxt_e;
endpackage

// File: rtl/prra_level_scan.sv
module prra_level_scan #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N*PW-1:0] pri_i,
  output logic [PW-1:0]   best_o,
  output logic [N-1:0]    mask_o
);
  always_comb begin
    best_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pri_i[i*PW +: PW] > best_o) best_o = pri_i[i*PW +: PW];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mask_o[i] = (best_o != '0) && (pri_i[i*PW +: PW] == best_o);
    end
  end

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (best_o != '0) |-> (mask_o != '0)); // R5
  AST_MASK_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (pri_i == '0) |-> (mask_o == '0)); // R5
endmodule

// File: rtl/prra_rr_pick.sv
module prra_rr_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] ptr_i,
  output logic [N-1:0]  pick_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    int j;
    pick_o = '0;
    idx_o  = '0;
    any_o  = 1'b0;
    j      = 0;
    for (int off = 1; off <= N; off++) begin
      j = (int'(ptr_i) + off) % N;
      if (!any_o && mask_i[j]) begin
        any_o     = 1'b1;
        pick_o[j] = 1'b1;
        idx_o     = IW'(j);
      end
    end
  end

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_o)); // R2
  AST_PICK_IN_MASK: assert property (@(posedge clk) disable iff (rst)
    ((pick_o & ~mask_i) == '0) && (any_o == (mask_i != '0))); // R4
endmodule

// File: rtl/prra_ptr_bank.sv
module prra_ptr_bank #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 3,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] rd_lvl_i,
  output logic [IW-1:0] rd_ptr_o,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_lvl_i,
  input  logic [IW-1:0] wr_idx_i
);
  localparam int unsigned NL = 2 ** PW;

  logic [IW-1:0] ptr_q [NL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NL; l++) ptr_q[l] <= IW'(N - 1);
    end else if (wr_en_i) begin
      ptr_q[wr_lvl_i] <= wr_idx_i;
    end
  end

  assign rd_ptr_o = ptr_q[rd_lvl_i];

  AST_PTR_REAL_LVL: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> (wr_lvl_i != '0)); // R4
  AST_PTR_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && rd_lvl_i == wr_lvl_i) |=> (rd_lvl_i != $past(wr_lvl_i)) || (rd_ptr_o == $past(wr_idx_i))); // R4
endmodule

// File: rtl/prra_arbiter.sv
module prra_arbiter #(
  parameter int unsigned N          = 8,
  parameter int unsigned PW         = prra_pkg::PRI_W,
  parameter int unsigned GNT_STAGES = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N*PW-1:0] req_pri_i,
  input  logic [N-1:0]    hold_i,
  input  logic            stop_i,
  output logic [PW-1:0]   cas_best_o,
  input  logic [PW-1:0]   cas_best_i,
  input  logic            cas_tok_i,
  output logic [N-1:0]    grant_o
);
  import prra_pkg::*;

  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] best;
  logic [N-1:0]  lvl_mask;
  logic [IW-1:0] cur_ptr;
  logic [N-1:0]  pick;
  logic [IW-1:0] pick_idx;
  logic          pick_any;
  logic [N-1:0]  own_q;
  logic          keep;
  logic          may_win;
  nxt_e          nxt;

  prra_level_scan #(.N(N), .PW(PW)) u_scan (
    .clk(clk), .rst(rst), .pri_i(req_pri_i), .best_o(best), .mask_o(lvl_mask)
  );

  prra_ptr_bank #(.N(N), .PW(PW), .IW(IW)) u_ptr (
    .clk(clk), .rst(rst), .rd_lvl_i(best), .rd_ptr_o(cur_ptr),
    .wr_en_i(nxt == NXT_NEW), .wr_lvl_i(best), .wr_idx_i(pick_idx)
  );

  prra_rr_pick #(.N(N), .IW(IW)) u_pick (
    .clk(clk), .rst(rst), .mask_i(lvl_mask), .ptr_i(cur_ptr),
    .pick_o(pick), .idx_o(pick_idx), .any_o(pick_any)
  );

  assign cas_best_o = best;
  assign keep       = |(own_q & hold_i);
  assign may_win    = pick_any && (cas_best_i == best) && cas_tok_i;

  always_comb begin
    if (keep)                  nxt = NXT_KEEP;
    else if (stop_i || !may_win) nxt = NXT_IDLE;
    else                       nxt = NXT_NEW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0;
    end else begin
      case (nxt)
        NXT_KEEP: own_q <= own_q;
        NXT_NEW:  own_q <= pick;
        default:  own_q <= '0;
      endcase
    end
  end

  generate
    if (GNT_STAGES <= 1) begin : g_direct
      assign grant_o = own_q;
    end else begin : g_pipe
      logic [N-1:0] dly_q [GNT_STAGES-1];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < GNT_STAGES - 1; s++) dly_q[s] <= '0;
        end else begin
          dly_q[0] <= own_q;
          for (int s = 1; s < GNT_STAGES - 1; s++) dly_q[s] <= dly_q[s-1];
        end
      end
      assign grant_o = dly_q[GNT_STAGES-2];
    end
  endgenerate

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(own_q)); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (|(own_q & hold_i)) |=> (own_q == $past(own_q))); // R6
  AST_STOP_NONEW: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !(|(own_q & hold_i))) |=> (own_q == '0)); // R7
  AST_NO_TOKEN: assert property (@(posedge clk) disable iff (rst)
    (!cas_tok_i && !(|(own_q & hold_i))) |=> (own_q == '0)); // R8
  AST_WIN_TOP_LVL: assert property (@(posedge clk) disable iff (rst)
    (!(|(own_q & hold_i)) && !stop_i && cas_tok_i && cas_best_i == cas_best_o && cas_best_o != '0)
      |=> (own_q != '0)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((req_pri_i == '0) && !(|(own_q & hold_i))) |=> (own_q == '0)); // R5
endmodule

// File: tb/prra_arbiter_tb.sv
module prra_arbiter_tb;
  localparam int N = 8;
  localparam int PW = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N*PW-1:0] req_pri = '0;
  logic [N-1:0]    hold = '0;
  logic            stop = 1'b0;
  logic [PW-1:0]   cas_best_o;
  logic [PW-1:0]   cas_best_i;
  logic            cas_tok = 1'b1;
  logic            casc_mode = 1'b0;
  logic [PW-1:0]   ext_best = '0;
  logic [N-1:0]    grant;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign cas_best_i = casc_mode ? ext_best : cas_best_o;

  prra_arbiter #(.N(N), .PW(PW), .GNT_STAGES(1)) u_dut (
    .clk(clk), .rst(rst), .req_pri_i(req_pri), .hold_i(hold), .stop_i(stop),
    .cas_best_o(cas_best_o), .cas_best_i(cas_best_i), .cas_tok_i(cas_tok),
    .grant_o(grant)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_gnt(input logic [N-1:0] exp, input string req);
    checks++;
    if (grant !== exp) begin
      fails++;
      $display("FAIL %s grant actual=%b expected=%b", req, grant, exp);
    end
  endtask

  task automatic chk_best(input logic [PW-1:0] exp, input string req);
    checks++;
    if (cas_best_o !== exp) begin
      fails++;
      $display("FAIL %s best actual=%0d expected=%0d", req, cas_best_o, exp);
    end
  endtask

  task automatic set_pri(input int m, input int p);
    req_pri[m*PW +: PW] = PW'(p);
  endtask

  task automatic idle();
    req_pri = '0; hold = '0; stop = 1'b0; cas_tok = 1'b1; casc_mode = 1'b0;
    step();
  endtask

  task automatic t_reset();
    repeat (2) step();
    chk_gnt('0, "R1");
    chk_best('0, "R10");
    rst = 1'b0;
    step();
    chk_gnt('0, "R5");
  endtask

  task automatic t_single_latency();
    idle();
    set_pri(5, 3);
    #0.5;
    chk_gnt('0, "R9");
    chk_best(3'd3, "R10");
    step();
    chk_gnt(8'b0010_0000, "R9");
  endtask

  task automatic t_priority();
    idle();
    set_pri(2, 4); set_pri(6, 7); set_pri(0, 1);
    step();
    chk_gnt(8'b0100_0000, "R3");
  endtask

  task automatic t_rotation();
    idle();
    set_pri(1, 5); set_pri(4, 5); set_pri(6, 5);
    step(); chk_gnt(8'b0000_0010, "R4");
    step(); chk_gnt(8'b0001_0000, "R4");
    step(); chk_gnt(8'b0100_0000, "R4");
    step(); chk_gnt(8'b0000_0010, "R4");
    idle();
    set_pri(0, 3); set_pri(4, 3);
    step(); chk_gnt(8'b0000_0001, "R4");
    step(); chk_gnt(8'b0001_0000, "R4");
  endtask

  task automatic t_hold();
    idle();
    set_pri(2, 1);
    step(); chk_gnt(8'b0000_0100, "R6");
    set_pri(7, 7); hold[2] = 1'b1;
    step(); chk_gnt(8'b0000_0100, "R6");
    step(); chk_gnt(8'b0000_0100, "R6");
    hold = '0;
    step(); chk_gnt(8'b1000_0000, "R6");
    req_pri = '0; set_pri(3, 6); hold[5] = 1'b1;
    step(); chk_gnt(8'b0000_1000, "R6");
  endtask

  task automatic t_stop();
    idle();
    stop = 1'b1; set_pri(0, 2);
    step(); chk_gnt('0, "R7");
    stop = 1'b0;
    step(); chk_gnt(8'b0000_0001, "R7");
    hold[0] = 1'b1; stop = 1'b1;
    step(); chk_gnt(8'b0000_0001, "R7");
    hold = '0;
    step(); chk_gnt('0, "R7");
    req_pri = '0; set_pri(1, 5); set_pri(4, 5); set_pri(6, 5);
    step(); step(); chk_gnt('0, "R7");
    stop = 1'b0;
    step(); chk_gnt(8'b0001_0000, "R7");
  endtask

  task automatic t_cascade();
    idle();
    casc_mode = 1'b1; ext_best = 3'd7; set_pri(3, 4);
    #0.5;
    chk_best(3'd4, "R10");
    step(); chk_gnt('0, "R8");
    ext_best = 3'd4; cas_tok = 1'b0;
    step(); chk_gnt('0, "R8");
    cas_tok = 1'b1;
    step(); chk_gnt(8'b0000_1000, "R8");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single_latency();
        t_priority();
        t_rotation();
        t_hold();
        t_stop();
        t_cascade();
        idle();
        chk_gnt('0, "R5");
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule